// File: doc/BRIEF.md
# Packet Page Allocator and Command Unit

This block owns a small pool of fixed-size packet pages (2048 bytes each) for an Ethernet controller. It tracks page ownership with one bit per page and keeps three ordered lists of page numbers: pages waiting to transmit, pages whose transmission has completed, and pages holding received frames. The packet memory itself lives outside the block. Only page numbers pass through here.

The host steers the block through a byte-wide command port. The top three bits of the byte pick one of eight operations. Together these allocate, release, queue and flush pages. A packet number register holds the page that some commands act on. The block reports the allocation result, the head of each queue and the number of free pages.

A transmit allocation that finds no free page stays pending. It is granted automatically the moment any page is released. The receive path takes pages through its own request input, and the transmit engine retires queued pages through a send strobe.

Top module: `pkt_page_alloc`

## Requirements
- R1: After the synchronous reset, `free_count` equals the page count, all three queue heads read 0x80, `alloc_result` is 0x00, `alloc_done` is 0 and `pnum_q` is 0.
- R2: A command acts only in a cycle with `cmd_valid` high, and bits 7:5 of `cmd_byte` select the operation. Bits 4:0 are ignored. Opcode 0 changes nothing.
- R3: Opcode 1 (allocate) takes the lowest-numbered free page, writes its number to `alloc_result`, sets `alloc_done`, and lowers `free_count` by one, all visible after the same clock edge.
- R4: Opcode 1 with no free page leaves `alloc_result` at 0x80 and `alloc_done` at 0. The request then stays pending.
- R5: Opcode 5 frees the page named in `pnum_q` and raises `free_count`. A value of `pnum_q` at or above the page count is ignored.
- R6: While `alloc_result` is 0x80, any release (opcode 4 or 5) immediately grants the lowest free page to the pending request: `alloc_result` gets its number and `alloc_done` rises.
- R7: When no command is valid, `rx_alloc` takes the lowest free page and appends it to the receive queue. If no page is free, or the receive queue is full, nothing happens.
- R8: Opcode 3 drops the receive head and keeps the page allocated. Opcode 4 drops the receive head and frees that page. Both do nothing when the receive queue is empty.
- R9: Each queue head output shows the oldest page number in that queue, or 0x80 when the queue is empty.
- R10: Opcode 6 appends `pnum_q` to the transmit queue. It is ignored when the queue already holds as many entries as there are pages, or when `pnum_q` is not a valid page.
- R11: When no command is valid, `tx_send` moves the transmit head to the completion queue. `done_pop` drops the completion head. An entry that would grow the completion queue beyond the page count is dropped.
- R12: Opcode 7 empties the transmit and completion queues and leaves page ownership unchanged.
- R13: Opcode 2 frees every page and empties all three queues. `alloc_result` is left unchanged.
- R14: `rx_alloc`, `tx_send`, `done_pop` and `alloc_ack` have no effect in a cycle with `cmd_valid` high. Otherwise `alloc_ack` clears `alloc_done`. `pnum_wr` loads `pnum_q` in any cycle, and a command in that same cycle still uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte is valid this cycle |
| cmd_byte | input | 8 | Command; bits 7:5 are the opcode |
| pnum_wr | input | 1 | Load the packet number register |
| pnum_in | input | 8 | New packet number register value |
| rx_alloc | input | 1 | Receive path requests a page |
| tx_send | input | 1 | Transmit engine retires the transmit head |
| done_pop | input | 1 | Drop the completion queue head |
| alloc_ack | input | 1 | Clear the allocation-done flag |
| pnum_q | output | 8 | Packet number register |
| alloc_result | output | 8 | Last granted page, 0x80 while pending |
| alloc_done | output | 1 | Allocation-done flag |
| tx_head | output | 8 | Transmit queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| free_count | output | $clog2(PAGES+1) | Number of unowned pages |

## Verification
A corrupted ownership mask appears after the next clock edge as a `free_count` that disagrees with the pages granted and released. It then shows a few commands later as a wrong page number in `alloc_result` or at a queue head. A fault in a queue's shift or fill logic appears at its head output on the first pop that uncovers the bad slot. A fault in the empty test appears at once as 0x80 missing from, or wrongly shown on, a head output. The stimulus mixes random commands with directed runs that fill the pool, hold a request pending and flush each queue, so such faults reach a port within a handful of cycles.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_RESET  = 3'd2,
    OP_RXPOP  = 3'd3,
    OP_RXFREE = 3'd4,
    OP_FREE   = 3'd5,
    OP_TXADD  = 3'd6,
    OP_TXCLR  = 3'd7
  } mmu_op_e;

  localparam logic [7:0] NO_PAGE = 8'h80;

endpackage

// File: rtl/pkt_shift_queue.sv
module pkt_shift_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  slot [DEPTH];
  logic [CW-1:0] cnt;
  logic          pop_ok;
  logic          push_ok;
  logic [IW-1:0] wr_at;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign head    = slot[0];
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (pop_ok || !full);
  assign wr_at   = pop_ok ? IW'(cnt - 1'b1) : IW'(cnt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else begin
      if (pop_ok) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          slot[i] <= slot[i+1];
        end
      end
      if (push_ok) begin
        slot[wr_at] <= din;
      end
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R10 / R11: the owner must never push into a full queue without popping
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    !(push && full && !pop && !clr));

endmodule

// File: rtl/pkt_low_free.sv
module pkt_low_free #(
  parameter int PAGES = 4,
  localparam int IW   = $clog2(PAGES)
) (
  input  logic [PAGES-1:0] mask,
  output logic             found,
  output logic [IW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (!mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_alloc_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int IW   = $clog2(PAGES),
  localparam int CW   = $clog2(PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          pnum_wr,
  input  logic [7:0]    pnum_in,
  input  logic          rx_alloc,
  input  logic          tx_send,
  input  logic          done_pop,
  input  logic          alloc_ack,
  output logic [7:0]    pnum_q,
  output logic [7:0]    alloc_result,
  output logic          alloc_done,
  output logic [7:0]    tx_head,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [CW-1:0] free_count
);

  logic [PAGES-1:0] own_mask;
  logic [PAGES-1:0] mask_mid;
  logic [PAGES-1:0] mask_nx;
  logic [PAGES-1:0] rel_bits;
  logic [PAGES-1:0] take_bits;
  mmu_op_e          op;
  logic             side;
  logic             pnum_ok;
  logic             rel_en;
  logic [IW-1:0]    rel_idx;
  logic             pending;
  logic             alloc_try;
  logic             rx_take;
  logic             found;
  logic [IW-1:0]    pick;
  logic             unused_low_bits;

  logic          rx_empty, rx_full, tx_empty, tx_full, dn_empty, dn_full;
  logic [IW-1:0] rx_slot, tx_slot, dn_slot;
  logic          rx_pop, tx_push, tx_pop, dn_push, dn_pop, q_reset, q_txclr;

  assign unused_low_bits = ^cmd_byte[4:0];

  // command decode
  assign op      = cmd_valid ? mmu_op_e'(cmd_byte[7:5]) : OP_NOP;
  assign side    = !cmd_valid;
  assign pnum_ok = (pnum_q < 8'(PAGES));
  assign pending = (alloc_result == NO_PAGE);

  // release path: opcode 5 names the page, opcode 4 takes the receive head
  assign rel_en   = ((op == OP_FREE) && pnum_ok) || ((op == OP_RXFREE) && !rx_empty);
  assign rel_idx  = (op == OP_RXFREE) ? rx_slot : pnum_q[IW-1:0];
  assign rel_bits = rel_en ? (PAGES'(1) << rel_idx) : '0;
  assign mask_mid = own_mask & ~rel_bits;

  pkt_low_free #(.PAGES(PAGES)) u_pick (
    .mask  (mask_mid),
    .found (found),
    .idx   (pick)
  );

  // grant: explicit allocate, or retry of a pending one on release
  assign alloc_try = (op == OP_ALLOC) || (rel_en && pending);
  assign rx_take   = side && rx_alloc && !rx_full && found;
  assign take_bits = (((alloc_try && found) || rx_take)) ? (PAGES'(1) << pick) : '0;
  assign mask_nx   = (op == OP_RESET) ? '0 : (mask_mid | take_bits);

  // queue controls
  assign q_reset = (op == OP_RESET);
  assign q_txclr = q_reset || (op == OP_TXCLR);
  assign rx_pop  = (op == OP_RXPOP) || (op == OP_RXFREE);
  assign tx_push = (op == OP_TXADD) && pnum_ok && !tx_full;
  assign tx_pop  = side && tx_send && !tx_empty;
  assign dn_pop  = side && done_pop && !dn_empty;
  assign dn_push = tx_pop && (!dn_full || dn_pop);

  pkt_shift_queue #(.DEPTH(PAGES), .W(IW)) u_rxq (
    .clk (clk), .rst (rst), .clr (q_reset),
    .push (rx_take), .pop (rx_pop), .din (pick),
    .head (rx_slot), .empty (rx_empty), .full (rx_full)
  );

  pkt_shift_queue #(.DEPTH(PAGES), .W(IW)) u_txq (
    .clk (clk), .rst (rst), .clr (q_txclr),
    .push (tx_push), .pop (tx_pop), .din (pnum_q[IW-1:0]),
    .head (tx_slot), .empty (tx_empty), .full (tx_full)
  );

  pkt_shift_queue #(.DEPTH(PAGES), .W(IW)) u_dnq (
    .clk (clk), .rst (rst), .clr (q_txclr),
    .push (dn_push), .pop (dn_pop), .din (tx_slot),
    .head (dn_slot), .empty (dn_empty), .full (dn_full)
  );

  assign rx_head   = rx_empty ? NO_PAGE : 8'(rx_slot);
  assign tx_head   = tx_empty ? NO_PAGE : 8'(tx_slot);
  assign done_head = dn_empty ? NO_PAGE : 8'(dn_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_mask     <= '0;
      free_count   <= CW'(PAGES);
      alloc_result <= 8'h00;
      alloc_done   <= 1'b0;
      pnum_q       <= 8'h00;
    end else begin
      own_mask   <= mask_nx;
      free_count <= CW'(PAGES - $countones(mask_nx));
      if (pnum_wr) begin
        pnum_q <= pnum_in;
      end
      if (alloc_try) begin
        alloc_result <= found ? 8'(pick) : NO_PAGE;
        alloc_done   <= found;
      end else if (side && alloc_ack) begin
        alloc_done <= 1'b0;
      end
    end
  end

  // R3: a grant with pages free sets the flag and consumes one page
  assert_alloc_take_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && free_count != '0)
      |=> (alloc_done && alloc_result != NO_PAGE && free_count == $past(free_count) - 1'b1));

  // R3: the free count never exceeds the pool
  assert_free_range_R3: assert property (@(posedge clk) disable iff (rst)
    free_count <= CW'(PAGES));

  // R4: allocate on an exhausted pool reports failure
  assert_alloc_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && free_count == '0)
      |=> (alloc_result == NO_PAGE && !alloc_done));

  // R6: a release while pending grants a page at once
  assert_retry_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'd5 && pnum_q < 8'(PAGES) && alloc_result == NO_PAGE)
      |=> (alloc_done && alloc_result != NO_PAGE));

  // R12: transmit flush empties both transmit-side queues, ownership kept
  assert_txclr_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'd7)
      |=> (tx_head == NO_PAGE && done_head == NO_PAGE && $stable(free_count)));

  // R13: allocator reset frees the pool and empties every queue
  assert_reset_R13: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'd2)
      |=> (free_count == CW'(PAGES) && rx_head == NO_PAGE
           && tx_head == NO_PAGE && done_head == NO_PAGE));

  // R2 / R14: opcode 0 with side strobes changes no page state
  assert_nop_quiet_R14: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7:5] == 3'd0)
      |=> ($stable(free_count) && $stable(rx_head) && $stable(tx_head) && $stable(done_head)));

endmodule

// File: tb/pkt_page_alloc_bench.sv
`timescale 1ns/1ps
module pkt_page_alloc_bench;

  localparam int P  = 4;
  localparam int CW = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic          pnum_wr = 1'b0;
  logic [7:0]    pnum_in = '0;
  logic          rx_alloc = 1'b0;
  logic          tx_send = 1'b0;
  logic          done_pop = 1'b0;
  logic          alloc_ack = 1'b0;
  logic [7:0]    pnum_q, alloc_result, tx_head, done_head, rx_head;
  logic          alloc_done;
  logic [CW-1:0] free_count;

  int checks = 0;
  int errors = 0;

  // expected state, built from the requirements
  bit [P-1:0] m_mask;
  int         m_rx[$];
  int         m_tx[$];
  int         m_dn[$];
  int         m_res;
  bit         m_done;
  int         m_pnum;

  always #2.5 clk = ~clk;

  pkt_page_alloc #(.PAGES(P)) u_pkt_page_alloc (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_byte (cmd_byte),
    .pnum_wr (pnum_wr), .pnum_in (pnum_in), .rx_alloc (rx_alloc),
    .tx_send (tx_send), .done_pop (done_pop), .alloc_ack (alloc_ack),
    .pnum_q (pnum_q), .alloc_result (alloc_result), .alloc_done (alloc_done),
    .tx_head (tx_head), .done_head (done_head), .rx_head (rx_head),
    .free_count (free_count)
  );

  function automatic int lowest(bit [P-1:0] m);
    for (int i = 0; i < P; i++) if (!m[i]) return i;
    return -1;
  endfunction

  function automatic int count_free(bit [P-1:0] m);
    int n = 0;
    for (int i = 0; i < P; i++) if (!m[i]) n++;
    return n;
  endfunction

  task automatic grant();
    int i = lowest(m_mask);
    if (i < 0) begin
      m_res = 128; m_done = 1'b0;
    end else begin
      m_mask[i] = 1'b1; m_res = i; m_done = 1'b1;
    end
  endtask

  task automatic model(bit cv, bit [7:0] cb, bit pw, bit [7:0] pv,
                       bit rxa, bit txs, bit dp, bit ack);
    int  op  = cv ? int'(cb[7:5]) : 0;
    bit  pend = (m_res == 128);
    int  rel = -1;
    case (op)
      1: grant();
      2: begin m_mask = '0; m_rx.delete(); m_tx.delete(); m_dn.delete(); end
      3: if (m_rx.size() > 0) void'(m_rx.pop_front());
      4: if (m_rx.size() > 0) rel = m_rx.pop_front();
      5: if (m_pnum < P) rel = m_pnum;
      6: if (m_pnum < P && m_tx.size() < P) m_tx.push_back(m_pnum);
      7: begin m_tx.delete(); m_dn.delete(); end
      default: ;
    endcase
    if (rel >= 0) begin
      m_mask[rel] = 1'b0;
      if (pend) grant();
    end
    if (!cv) begin
      if (rxa && m_rx.size() < P) begin
        int i = lowest(m_mask);
        if (i >= 0) begin m_mask[i] = 1'b1; m_rx.push_back(i); end
      end
      if (dp && m_dn.size() > 0) void'(m_dn.pop_front());
      if (txs && m_tx.size() > 0) begin
        int e = m_tx.pop_front();
        if (m_dn.size() < P) m_dn.push_back(e);
      end
      if (ack) m_done = 1'b0;
    end
    if (pw) m_pnum = pv;
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int headof(int q[$]);
    return (q.size() > 0) ? q[0] : 128;
  endfunction

  task automatic check_all(string tag);
    cmp(tag, "alloc_result", int'(alloc_result), m_res);
    cmp(tag, "alloc_done", int'(alloc_done), int'(m_done));
    cmp(tag, "free_count", int'(free_count), count_free(m_mask));
    cmp(tag, "rx_head", int'(rx_head), headof(m_rx));
    cmp(tag, "tx_head", int'(tx_head), headof(m_tx));
    cmp(tag, "done_head", int'(done_head), headof(m_dn));
    cmp(tag, "pnum_q", int'(pnum_q), m_pnum);
  endtask

  // one cycle: drive at the falling edge, compare at the next falling edge
  task automatic step(string tag, bit cv, bit [7:0] cb, bit pw = 0, bit [7:0] pv = 0,
                      bit rxa = 0, bit txs = 0, bit dp = 0, bit ack = 0);
    cmd_valid = cv; cmd_byte = cb; pnum_wr = pw; pnum_in = pv;
    rx_alloc = rxa; tx_send = txs; done_pop = dp; alloc_ack = ack;
    model(cv, cb, pw, pv, rxa, txs, dp, ack);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic setp(string tag, bit [7:0] v);
    step(tag, 1'b0, 8'h00, 1'b1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_mask = '0; m_res = 0; m_done = 1'b0; m_pnum = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // R3: four grants, lowest first
    for (int k = 0; k < P; k++) step("R3 alloc", 1'b1, 8'h20);
    // R4: exhausted pool
    step("R4 alloc fail", 1'b1, 8'h3F);
    // R2 / R14: opcode 0 with low bits and side strobes
    step("R2 nop", 1'b1, 8'h1F, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R6: release page 2 while pending
    setp("R14 pnum", 8'd2);
    step("R6 retry", 1'b1, 8'hA0);
    step("R14 ack", 1'b0, 8'h00, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R5: plain release and out-of-range release
    setp("R5 pnum", 8'd1);
    step("R5 release", 1'b1, 8'hA0);
    setp("R5 pnum", 8'd9);
    step("R5 release ignored", 1'b1, 8'hA0);
    // R7: receive takes the freed page, then nothing left
    step("R7 rx take", 1'b0, 8'h00, 1'b0, 8'h0, 1'b1);
    step("R7 rx none", 1'b0, 8'h00, 1'b0, 8'h0, 1'b1);
    step("R14 rx ignored", 1'b1, 8'h00, 1'b0, 8'h0, 1'b1);
    // R10: fill transmit queue, then overflow and invalid page ignored
    step("R14 pnum same cycle", 1'b1, 8'hC0, 1'b1, 8'd3);
    for (int k = 0; k < P; k++) step("R10 tx add", 1'b1, 8'hC0);
    setp("R10 pnum", 8'd7);
    step("R10 bad page", 1'b1, 8'hC0);
    // R11: move to completion, pop, overflow drop
    step("R11 send", 1'b0, 8'h00, 1'b0, 8'h0, 1'b0, 1'b1);
    step("R11 send pop", 1'b0, 8'h00, 1'b0, 8'h0, 1'b0, 1'b1, 1'b1);
    step("R11 pop", 1'b0, 8'h00, 1'b0, 8'h0, 1'b0, 1'b0, 1'b1);
    // R12: flush transmit side
    step("R12 txclr", 1'b1, 8'hE0);
    // R8 / R9: pop receive keeping page, then empty head
    step("R8 rx pop", 1'b1, 8'h60);
    step("R9 rx empty", 1'b1, 8'h60);
    step("R8 rxfree empty", 1'b1, 8'h80);
    // R8: receive then pop-and-free
    setp("R8 pnum", 8'd0);
    step("R8 free0", 1'b1, 8'hA0);
    step("R8 rx take", 1'b0, 8'h00, 1'b0, 8'h0, 1'b1);
    step("R8 rxfree", 1'b1, 8'h80);
    // R13: allocator reset leaves result
    step("R13 mmu reset", 1'b1, 8'h40);
    step("R3 after reset", 1'b1, 8'h20);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit       cv = ($urandom_range(0, 2) != 0);
      bit [7:0] cb = {3'($urandom_range(0, 7)), 5'($urandom)};
      bit       pw = ($urandom_range(0, 3) == 0);
      bit [7:0] pv = 8'($urandom_range(0, 5));
      if (cb[7:5] == 3'd2 && $urandom_range(0, 7) != 0) cb[7:5] = 3'd1;
      step("R3-R14 random", cv, cb, pw, pv,
           ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule